// File: doc/BRIEF.md
# Linked-Table DMA Buffer Writer

This block moves a stream of 32-bit data words into host memory. Host memory is organised as a closed ring of descriptor tables. Each table is one 4096-byte page. Word 0 of a table holds the frame number of the next table in the ring, and the words after it hold the frame numbers of the buffer pages. A frame number is a byte address shifted right by the page shift (12 by default). The writer fetches a table's next pointer and then one buffer pointer at a time. It fills each buffer page with incoming words in arrival order, and once the last buffer is full it moves on to the next table in the ring.

Software controls the walk through a small command port. One command loads the first table's frame number, one starts the walk and one stops it. Two more commands clear and increment a table credit counter. Software grants one credit for each table it has prepared and one for each table it has drained. The writer needs at least one credit to enter a table and gives one back when it finishes that table. If no credit is left at a table boundary, it holds the input stream off. Software detects a filled page by a nonzero final word, so the writer always writes that word last and never writes it as zero. A status group reports whether the walk is running, the table and buffer position, and the credit count.

Top module: `ring_table_writer`

## Requirements
- R1: After reset the block is idle: `stat_running`=0, `stat_credits`=0, `stat_table_idx`=0, `stat_buf_idx`=0, `mem_req`=0 and `in_ready`=0.
- R2: Command codes on `cmd_code` are 0 = load first table frame number from `cmd_data`, 1 = start, 2 = stop, 3 = clear credits, 4 = add one credit. A start from idle begins the walk at the loaded table with the table and buffer positions at zero.
- R3: Clear sets the credit count to 0 and takes priority over everything else. Add raises the count by one and saturates at 2^CREDIT_W-1.
- R4: On entering a table the writer reads byte address (table frame << PAGE_SHIFT) to get the next-table frame number. Before buffer i it reads the table word at byte offset 4*(i+1) to get that buffer's frame number.
- R5: Word w of a buffer page is written to byte address (buffer frame << PAGE_SHIFT) + 4*w. Words are written in arrival order, so the final word of the page is the last one written.
- R6: When MARK_MODE is 0, a final word of value 0 is written as FILL_MARK (default 1). A nonzero final word, and any word that is not final, is written unchanged.
- R7: After the last buffer of a table, the walk continues at the frame number read from that table's word 0. A ring whose last table points to the first therefore wraps around.
- R8: When the final word of a table's last page is accepted, the credit count drops by one (it never goes below 0), `stat_table_idx` advances by one modulo 2^TIDX_W, and `stat_buf_idx` returns to 0.
- R9: At a table boundary with zero credits the writer issues no memory request and keeps `in_ready` low until a credit arrives.
- R10: Stop returns the block to idle and abandons the page in progress. A read already in flight is allowed to complete first. While idle, no memory request is issued and `in_ready` stays low.
- R11: `stat_running` is 1 from start until stop. `stat_buf_idx` gives the index of the buffer page currently being filled within its table.
- R12: `in_ready` is high only while a page write is in progress and `mem_gnt` is high, so each accepted word is the write that the memory takes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code (see R2) |
| cmd_data | input | PFN_W | First table frame number for code 0 |
| in_valid | input | 1 | Stream word valid |
| in_data | input | DATA_W | Stream word |
| in_ready | output | 1 | Stream word accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | PFN_W+PAGE_SHIFT | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Memory takes the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| stat_running | output | 1 | Walk active |
| stat_table_idx | output | TIDX_W | Tables completed since start, modulo 2^TIDX_W |
| stat_buf_idx | output | max(1,clog2(TABLE_BUFS)) | Buffer page being filled |
| stat_credits | output | CREDIT_W | Table credit count |

## Verification
The bench builds the writer with 4 words per page, 3 buffers per table, a 3-bit credit counter and a 4-bit table index, over a ring of 3 tables. With these sizes a few dozen words finish whole tables, so the bench can reach ring wrap-around, the credit stall at a table boundary, credit saturation and table-index advance within a short run. The grant line follows a stall pattern and read data comes back two cycles late. This exercises the coupling between stream acceptance and grant, and it shows that a stop or a table boundary never lets a word through.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

   typedef enum logic [2:0] {
      CMD_LOAD_FIRST = 3'd0,
      CMD_START      = 3'd1,
      CMD_STOP       = 3'd2,
      CMD_CRED_CLR   = 3'd3,
      CMD_CRED_ADD   = 3'd4
   } rtw_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WCRED  = 3'd1,
      ST_RDREQ  = 3'd2,
      ST_RDWAIT = 3'd3,
      ST_WRITE  = 3'd4
   } rtw_state_e;

endpackage

// File: rtl/rtw_cmd.sv
module rtw_cmd
   import rtw_pkg::*;
#(
   parameter int PFN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_code,
   input  logic [PFN_W-1:0] cmd_data,
   output logic [PFN_W-1:0] first_pfn,
   output logic             go_start,
   output logic             go_stop,
   output logic             cred_clr,
   output logic             cred_add
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_pfn <= '0;
      end else if (cmd_valid && cmd_code == CMD_LOAD_FIRST) begin
         first_pfn <= cmd_data;
      end
   end

   assign go_start = cmd_valid && (cmd_code == CMD_START);
   assign go_stop  = cmd_valid && (cmd_code == CMD_STOP);
   assign cred_clr = cmd_valid && (cmd_code == CMD_CRED_CLR);
   assign cred_add = cmd_valid && (cmd_code == CMD_CRED_ADD);

endmodule

// File: rtl/rtw_credit.sv
module rtw_credit #(
   parameter int CREDIT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                add,
   input  logic                take,
   output logic [CREDIT_W-1:0] credits
);

   localparam logic [CREDIT_W-1:0] CMAX = '1;

   if (CREDIT_W < 1) begin : g_chk_w
      $error("rtw_credit: CREDIT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credits <= '0;
      end else if (clr) begin
         credits <= '0;
      end else if (add && !take) begin
         if (credits != CMAX) credits <= credits + CREDIT_W'(1);
      end else if (take && !add) begin
         if (credits != '0) credits <= credits - CREDIT_W'(1);
      end
   end

   AST_CREDIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> credits == '0); // R3
   AST_CREDIT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && add && !take && credits == CMAX) |=> credits == CMAX); // R3
   AST_CREDIT_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && add && !take && credits != CMAX) |=> credits == CREDIT_W'($past(credits) + 1'b1)); // R3
   AST_CREDIT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && take && !add && credits != '0) |=> credits == CREDIT_W'($past(credits) - 1'b1)); // R8

endmodule

// File: rtl/rtw_mark.sv
module rtw_mark #(
   parameter int          DATA_W    = 32,
   parameter int          MARK_MODE = 0,
   parameter logic [31:0] FILL_MARK = 32'd1
) (
   input  logic [DATA_W-1:0] din,
   input  logic              is_final,
   output logic [DATA_W-1:0] dout
);

   localparam logic [DATA_W-1:0] FILL = DATA_W'(FILL_MARK);

   if (FILL == '0) begin : g_chk_fill
      $error("rtw_mark: FILL_MARK must be nonzero");
   end

   if (MARK_MODE == 0) begin : g_subst
      assign dout = (is_final && din == '0) ? FILL : din;
   end else if (MARK_MODE == 1) begin : g_force
      assign dout = is_final ? (din | FILL) : din;
   end else begin : g_bad_mode
      $error("rtw_mark: MARK_MODE must be 0 or 1");
   end

endmodule

// File: rtl/rtw_walker.sv
module rtw_walker
   import rtw_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   parameter int PAGE_WORDS = 1024,
   parameter int TABLE_BUFS = 511,
   parameter int DATA_W     = 32,
   parameter int PFN_W      = 32,
   parameter int TIDX_W     = 8,
   localparam int AW        = PFN_W + PAGE_SHIFT,
   localparam int WIDX_W    = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1,
   localparam int BIDX_W    = (TABLE_BUFS > 1) ? $clog2(TABLE_BUFS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_start,
   input  logic              go_stop,
   input  logic [PFN_W-1:0]  first_pfn,
   input  logic              has_credit,
   output logic              table_done,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              final_word,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              running,
   output logic [TIDX_W-1:0] table_idx,
   output logic [BIDX_W-1:0] buf_idx
);

   localparam int OFS_W = $clog2(TABLE_BUFS + 1);

   rtw_state_e          state_q;
   logic [PFN_W-1:0]    tbl_pfn_q, next_pfn_q, buf_pfn_q;
   logic [WIDX_W-1:0]   word_idx_q;
   logic [BIDX_W-1:0]   buf_idx_q;
   logic [TIDX_W-1:0]   table_idx_q;
   logic                rd_is_next_q;
   logic                stop_pend_q;
   logic                stop_go, wr_fire, last_w, last_b;
   logic [OFS_W-1:0]    rd_word;
   logic [AW-1:0]       rd_addr, wr_addr;

   assign stop_go = go_stop || stop_pend_q;
   assign wr_fire = (state_q == ST_WRITE) && in_valid && mem_gnt;
   assign last_w  = (word_idx_q == WIDX_W'(PAGE_WORDS - 1));
   assign last_b  = (buf_idx_q == BIDX_W'(TABLE_BUFS - 1));

   assign rd_word = rd_is_next_q ? '0 : OFS_W'(buf_idx_q) + OFS_W'(1);
   assign rd_addr = {tbl_pfn_q, {PAGE_SHIFT{1'b0}}} | (AW'(rd_word) << 2);
   assign wr_addr = {buf_pfn_q, {PAGE_SHIFT{1'b0}}} | (AW'(word_idx_q) << 2);

   assign mem_req    = (state_q == ST_RDREQ) || ((state_q == ST_WRITE) && in_valid);
   assign mem_we     = (state_q == ST_WRITE);
   assign mem_addr   = (state_q == ST_WRITE) ? wr_addr : rd_addr;
   assign in_ready   = (state_q == ST_WRITE) && mem_gnt;
   assign final_word = last_w;
   assign table_done = wr_fire && !stop_go && last_w && last_b;

   assign running   = (state_q != ST_IDLE);
   assign table_idx = table_idx_q;
   assign buf_idx   = buf_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         tbl_pfn_q    <= '0;
         next_pfn_q   <= '0;
         buf_pfn_q    <= '0;
         word_idx_q   <= '0;
         buf_idx_q    <= '0;
         table_idx_q  <= '0;
         rd_is_next_q <= 1'b0;
         stop_pend_q  <= 1'b0;
      end else begin
         if (go_stop && state_q != ST_IDLE) stop_pend_q <= 1'b1;
         case (state_q)
            ST_IDLE: begin
               stop_pend_q <= 1'b0;
               if (go_start) begin
                  tbl_pfn_q   <= first_pfn;
                  table_idx_q <= '0;
                  buf_idx_q   <= '0;
                  word_idx_q  <= '0;
                  state_q     <= ST_WCRED;
               end
            end
            ST_WCRED: begin
               if (stop_go) begin
                  state_q     <= ST_IDLE;
                  stop_pend_q <= 1'b0;
               end else if (has_credit) begin
                  rd_is_next_q <= 1'b1;
                  state_q      <= ST_RDREQ;
               end
            end
            ST_RDREQ: begin
               if (mem_gnt) begin
                  state_q <= ST_RDWAIT;
               end else if (stop_go) begin
                  state_q     <= ST_IDLE;
                  stop_pend_q <= 1'b0;
               end
            end
            ST_RDWAIT: begin
               if (mem_rvalid) begin
                  if (stop_go) begin
                     state_q     <= ST_IDLE;
                     stop_pend_q <= 1'b0;
                  end else if (rd_is_next_q) begin
                     next_pfn_q   <= mem_rdata[PFN_W-1:0];
                     rd_is_next_q <= 1'b0;
                     state_q      <= ST_RDREQ;
                  end else begin
                     buf_pfn_q  <= mem_rdata[PFN_W-1:0];
                     word_idx_q <= '0;
                     state_q    <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (stop_go) begin
                  state_q     <= ST_IDLE;
                  stop_pend_q <= 1'b0;
               end else if (wr_fire) begin
                  if (last_w) begin
                     word_idx_q <= '0;
                     if (last_b) begin
                        buf_idx_q   <= '0;
                        table_idx_q <= table_idx_q + TIDX_W'(1);
                        tbl_pfn_q   <= next_pfn_q;
                        state_q     <= ST_WCRED;
                     end else begin
                        buf_idx_q <= buf_idx_q + BIDX_W'(1);
                        state_q   <= ST_RDREQ;
                     end
                  end else begin
                     word_idx_q <= word_idx_q + WIDX_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_STALL_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WCRED && !has_credit && !stop_go) |=> (state_q == ST_WCRED)); // R9
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!mem_req && !in_ready)); // R10
   AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDWAIT && !mem_rvalid) |=> (state_q == ST_RDWAIT)); // R10
   AST_TABLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      table_done |=> (buf_idx_q == '0 && table_idx_q == TIDX_W'($past(table_idx_q) + 1'b1))); // R8
   AST_BUF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_idx_q <= BIDX_W'(TABLE_BUFS - 1)); // R11

endmodule

// File: rtl/ring_table_writer.sv
module ring_table_writer
   import rtw_pkg::*;
#(
   parameter int          PAGE_SHIFT = 12,
   parameter int          PAGE_WORDS = 1024,
   parameter int          TABLE_BUFS = 511,
   parameter int          DATA_W     = 32,
   parameter int          PFN_W      = 32,
   parameter int          CREDIT_W   = 8,
   parameter int          TIDX_W     = 8,
   parameter int          MARK_MODE  = 0,
   parameter logic [31:0] FILL_MARK  = 32'd1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmd_valid,
   input  logic [2:0]                    cmd_code,
   input  logic [PFN_W-1:0]              cmd_data,
   input  logic                          in_valid,
   input  logic [DATA_W-1:0]             in_data,
   output logic                          in_ready,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [PFN_W+PAGE_SHIFT-1:0]   mem_addr,
   output logic [DATA_W-1:0]             mem_wdata,
   input  logic                          mem_gnt,
   input  logic                          mem_rvalid,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic                          stat_running,
   output logic [TIDX_W-1:0]             stat_table_idx,
   output logic [((TABLE_BUFS > 1) ? $clog2(TABLE_BUFS) : 1)-1:0] stat_buf_idx,
   output logic [CREDIT_W-1:0]           stat_credits
);

   localparam int PAGE_SLOTS = 2 ** (PAGE_SHIFT - 2);

   if (DATA_W != 32) begin : g_chk_dw
      $error("ring_table_writer: words are 4 bytes, DATA_W must be 32");
   end
   if (PFN_W < 1 || PFN_W > DATA_W) begin : g_chk_pfn
      $error("ring_table_writer: PFN_W must fit in one word");
   end
   if (PAGE_SHIFT < 3) begin : g_chk_shift
      $error("ring_table_writer: PAGE_SHIFT too small");
   end
   if (PAGE_WORDS < 1 || PAGE_WORDS > PAGE_SLOTS) begin : g_chk_words
      $error("ring_table_writer: PAGE_WORDS must fit in one page");
   end
   if (TABLE_BUFS < 1 || TABLE_BUFS + 1 > PAGE_SLOTS) begin : g_chk_bufs
      $error("ring_table_writer: table entries plus next pointer must fit in one page");
   end
   if (TIDX_W < 1) begin : g_chk_tidx
      $error("ring_table_writer: TIDX_W must be at least 1");
   end

   logic [PFN_W-1:0] first_pfn;
   logic             go_start, go_stop, cred_clr, cred_add;
   logic             table_done, final_word;

   rtw_cmd #(.PFN_W(PFN_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_data  (cmd_data),
      .first_pfn (first_pfn),
      .go_start  (go_start),
      .go_stop   (go_stop),
      .cred_clr  (cred_clr),
      .cred_add  (cred_add)
   );

   rtw_credit #(.CREDIT_W(CREDIT_W)) u_credit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cred_clr),
      .add     (cred_add),
      .take    (table_done),
      .credits (stat_credits)
   );

   rtw_walker #(
      .PAGE_SHIFT (PAGE_SHIFT),
      .PAGE_WORDS (PAGE_WORDS),
      .TABLE_BUFS (TABLE_BUFS),
      .DATA_W     (DATA_W),
      .PFN_W      (PFN_W),
      .TIDX_W     (TIDX_W)
   ) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_start   (go_start),
      .go_stop    (go_stop),
      .first_pfn  (first_pfn),
      .has_credit (stat_credits != '0),
      .table_done (table_done),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .final_word (final_word),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .running    (stat_running),
      .table_idx  (stat_table_idx),
      .buf_idx    (stat_buf_idx)
   );

   rtw_mark #(
      .DATA_W    (DATA_W),
      .MARK_MODE (MARK_MODE),
      .FILL_MARK (FILL_MARK)
   ) u_mark (
      .din      (in_data),
      .is_final (final_word),
      .dout     (mem_wdata)
   );

   AST_FINAL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && final_word) |-> mem_wdata != '0); // R6
   AST_READY_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |-> (mem_req && mem_we && mem_gnt)); // R12

endmodule

// File: tb/tb_ring_table_writer.sv
module tb_ring_table_writer;
   import rtw_pkg::*;

   localparam int W  = 4;
   localparam int B  = 3;
   localparam int T  = 3;
   localparam int CW = 3;
   localparam int TW = 4;
   localparam int PS = 12;
   localparam int AW = 32 + PS;
   localparam int BW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_code = '0;
   logic [31:0] cmd_data = '0;
   logic in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic in_ready;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic mem_gnt = 1'b0;
   logic mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic stat_running;
   logic [TW-1:0] stat_table_idx;
   logic [BW-1:0] stat_buf_idx;
   logic [CW-1:0] stat_credits;

   ring_table_writer #(
      .PAGE_SHIFT (PS), .PAGE_WORDS (W), .TABLE_BUFS (B), .DATA_W (32),
      .PFN_W (32), .CREDIT_W (CW), .TIDX_W (TW), .MARK_MODE (0), .FILL_MARK (32'd1)
   ) dut (.*);

   always #4 clk = ~clk;

   logic [31:0] mem [longint];
   logic [31:0] stm_q[$];
   logic [AW-1:0] exp_addr[$];
   logic [31:0] exp_data[$];
   int total = 0, bad = 0, cyc = 0, acc_cnt = 0;
   bit done = 1'b0;
   int mdl_t, mdl_b, mdl_w;
   logic [AW-1:0] last_wr_addr = '0;
   bit rd_pend = 1'b0;
   int rd_cnt = 0;
   logic [31:0] rd_val = '0;

   function automatic logic [31:0] tbl_pfn(int t);
      return 32'h100 * (t + 1);
   endfunction
   function automatic logic [31:0] buf_pfn(int t, int b);
      return 32'h1000 + 32'h10 * t + b;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model, stream driver and write monitor
   always @(negedge clk) begin
      cyc++;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
         if (rd_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd_val;
            rd_pend    = 1'b0;
         end else rd_cnt--;
      end
      mem_gnt  = (cyc % 5) != 3;
      in_valid = stm_q.size() > 0;
      in_data  = in_valid ? stm_q[0] : 32'h0;
      #1;
      if (rst_n) begin
         if (in_ready) begin
            total++;
            if (!(mem_gnt && mem_we)) begin
               bad++;
               $display("FAIL R12 in_ready with gnt=%0b we=%0b expected 1 1", mem_gnt, mem_we);
            end
         end
         if (mem_req && mem_gnt) begin
            if (mem_we) begin
               if (exp_addr.size() == 0) begin
                  total++; bad++;
                  $display("FAIL R5 R10 unexpected write addr=%0h data=%0h expected none", mem_addr, mem_wdata);
               end else begin
                  chk("R5 write address", longint'(mem_addr), longint'(exp_addr[0]));
                  chk("R5 R6 write data", longint'(mem_wdata), longint'(exp_data[0]));
                  void'(exp_addr.pop_front());
                  void'(exp_data.pop_front());
               end
               last_wr_addr = mem_addr;
            end else begin
               chk("R4 read of populated table word", longint'(mem.exists(longint'(mem_addr))), 1);
               rd_val  = mem.exists(longint'(mem_addr)) ? mem[longint'(mem_addr)] : 32'h0;
               rd_pend = 1'b1;
               rd_cnt  = 1;
            end
         end
         if (in_valid && in_ready) begin
            void'(stm_q.pop_front());
            acc_cnt++;
         end
      end
   end

   always @(posedge clk) begin
      if (!done && cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic cmd(input logic [2:0] code, input logic [31:0] data);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic drain;
      while (exp_addr.size() != 0 || stm_q.size() != 0) @(negedge clk);
   endtask

   task automatic model_start(input int t);
      mdl_t = t; mdl_b = 0; mdl_w = 0;
   endtask

   // driver: pushes stream words and the writes they must produce
   task automatic push(input int n, input logic [31:0] seed, input bit zeros);
      for (int i = 0; i < n; i++) begin
         logic [31:0] d;
         d = seed + 32'h01010101 * i;
         if (zeros && (mdl_w == W - 1 || mdl_w == 1)) d = 32'h0;
         stm_q.push_back(d);
         exp_addr.push_back({buf_pfn(mdl_t % T, mdl_b), 12'h0} + AW'(4 * mdl_w));
         exp_data.push_back((mdl_w == W - 1 && d == 32'h0) ? 32'h1 : d);
         mdl_w++;
         if (mdl_w == W) begin
            mdl_w = 0; mdl_b++;
            if (mdl_b == B) begin mdl_b = 0; mdl_t++; end
         end
      end
   endtask

   initial begin
      int acc0;
      for (int t = 0; t < T; t++) begin
         mem[longint'({tbl_pfn(t), 12'h0})] = tbl_pfn((t + 1) % T);
         for (int b = 0; b < B; b++)
            mem[longint'({tbl_pfn(t), 12'h0} + 4 * (b + 1))] = buf_pfn(t, b);
      end
      settle(4);
      chk("R1 running in reset", stat_running, 0);
      chk("R1 mem_req in reset", mem_req, 0);
      @(negedge clk); rst_n = 1'b1;
      settle(3);
      chk("R1 running", stat_running, 0);
      chk("R1 credits", stat_credits, 0);
      chk("R1 table_idx", stat_table_idx, 0);
      chk("R1 buf_idx", stat_buf_idx, 0);
      chk("R1 in_ready", in_ready, 0);
      chk("R1 mem_req", mem_req, 0);

      cmd(CMD_LOAD_FIRST, tbl_pfn(0));
      cmd(CMD_CRED_CLR, 0);
      repeat (3) cmd(CMD_CRED_ADD, 0);
      settle(2);
      chk("R3 credits after three adds", stat_credits, 3);
      chk("R2 not running before start", stat_running, 0);

      model_start(0);
      cmd(CMD_START, 0);
      push(W * B, 32'h11223344, 1'b0);
      push(W * B, 32'h55000000, 1'b1);
      drain; settle(20);
      chk("R2 running after start", stat_running, 1);
      chk("R8 credits after two tables", stat_credits, 1);
      chk("R8 R11 table_idx after two tables", stat_table_idx, 2);
      chk("R8 R11 buf_idx at table entry", stat_buf_idx, 0);

      push(W * B, 32'hC0DE0001, 1'b1);
      drain; settle(20);
      chk("R8 credits exhausted", stat_credits, 0);
      chk("R8 table_idx after three tables", stat_table_idx, 3);

      acc0 = acc_cnt;
      push(W, 32'h77770000, 1'b0);
      settle(40);
      chk("R9 no word accepted without credit", acc_cnt - acc0, 0);
      chk("R9 stream held", stm_q.size(), W);
      chk("R9 no request while stalled", mem_req, 0);
      chk("R9 in_ready low while stalled", in_ready, 0);

      cmd(CMD_CRED_ADD, 0);
      drain; settle(20);
      chk("R7 ring wrap writes table 0 page 0", longint'(last_wr_addr),
          longint'({buf_pfn(0, 0), 12'h0} + AW'(4 * (W - 1))));
      chk("R7 table_idx after wrap", stat_table_idx, 3);
      chk("R11 buf_idx moved to next page", stat_buf_idx, 1);
      chk("R3 credit added during stall", stat_credits, 1);

      push(2, 32'h99990000, 1'b0);
      drain;
      cmd(CMD_STOP, 0);
      settle(5);
      chk("R10 R11 running after stop", stat_running, 0);
      acc0 = acc_cnt;
      stm_q.push_back(32'hDEAD0001);
      stm_q.push_back(32'hDEAD0002);
      stm_q.push_back(32'hDEAD0003);
      settle(30);
      chk("R10 no word accepted while stopped", acc_cnt - acc0, 0);
      chk("R10 in_ready low while stopped", in_ready, 0);
      chk("R10 mem_req low while stopped", mem_req, 0);
      stm_q.delete();

      cmd(CMD_LOAD_FIRST, tbl_pfn(1));
      model_start(1);
      cmd(CMD_START, 0);
      settle(2);
      chk("R2 restart buf_idx", stat_buf_idx, 0);
      chk("R2 restart table_idx", stat_table_idx, 0);
      push(W * B, 32'hABCD0000, 1'b1);
      drain; settle(20);
      chk("R2 restart walks loaded table", longint'(last_wr_addr),
          longint'({buf_pfn(1, B - 1), 12'h0} + AW'(4 * (W - 1))));
      chk("R8 table_idx after restart table", stat_table_idx, 1);
      chk("R8 credits after restart table", stat_credits, 0);

      repeat (9) cmd(CMD_CRED_ADD, 0);
      settle(2);
      chk("R3 credits saturate", stat_credits, 7);
      cmd(CMD_CRED_CLR, 0);
      settle(2);
      chk("R3 clear", stat_credits, 0);
      settle(10);
      chk("R3 no write after clear", exp_addr.size(), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule